// File: doc/BRIEF.md
# CPU Clock Source and Prescaler Control

This block holds one byte-wide control register that picks where the CPU clock comes from and how far it is divided. There are three sources: a high-speed crystal clock, an internal ring-oscillator clock and a slow subsystem clock. Each source reaches the block as a one-cycle tick on a common system clock. A main-mode input chooses between the crystal and the ring oscillator whenever the subsystem clock is not selected. The block produces the CPU clock as a stream of single-cycle enable pulses, with one pulse for each completed divided period. It also drives the oscillator-stop and feedback-resistor control bits, and a live flag that is high while the CPU runs from the subsystem clock.

Software reaches the register over a simple bus with address, write strobe, read strobe and data. Which divide ratios are legal depends on the source. The crystal path offers divide by 1 to 16. The ring path offers only divide by 1 or 2. The subsystem path is fixed at divide by 2. A write that asks for anything else is dropped as a whole and raises a sticky error flag. A new source or ratio is taken up only when the current divided period ends, so the CPU enable stream never has a shortened period.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `cfg_err`, `cpu_ce`, `osc_stop`, `fb_off` and `sub_active` are 0, and the active path is the crystal clock divided by 1.
- R2: The register answers only at byte address 0xFFFB. A read returns data on `bus_rdata` one cycle after the strobe. `bus_rdata` is 0 on any cycle without a read that hits the register. Writes to other addresses change nothing.
- R3: Read layout: bit 7 oscillator stop, bit 6 feedback-resistor off, bit 5 live subsystem status, bit 4 subsystem select, bit 3 always 0, bits 2:0 divide code. Written values of bits 5 and 3 are never stored.
- R4: With subsystem select 0 and `main_mode` 0 (crystal path), codes 0 to 4 divide `hs_tick` by 1, 2, 4, 8 and 16. `cpu_ce` pulses one cycle after every 2^code-th counted tick.
- R5: With subsystem select 0 and `main_mode` 1 (ring path), codes 0 and 1 divide `ro_tick` by 1 and 2. Codes 2 to 7 are rejected.
- R6: With subsystem select 1, code 0 divides `sub_tick` by 2. Any other code is rejected.
- R7: A write with bit 3 set, or with a combination not allowed by R4 to R6 (for example, crystal code 5 to 7), leaves the whole register unchanged. It also sets `cfg_err`, which stays 1 until reset.
- R8: A new source or ratio takes effect only on the tick that ends the current divided period, at the same edge as that period's `cpu_ce` pulse.
- R9: `osc_stop` equals stored bit 7 only while the subsystem clock is the active source, and is 0 otherwise. `fb_off` follows stored bit 6. Both lag the state they follow by one cycle.
- R10: If `main_mode` moves to the ring path while a stored crystal code of 2 or more is in place, the ring path divides by 2 from the next period boundary.
- R11: `sub_active` is 1 exactly while the active source is the subsystem clock, and it changes at the period boundary where the switch happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| main_mode | input | 1 | Main path choice: 0 crystal, 1 ring oscillator |
| hs_tick | input | 1 | Crystal clock edge tick |
| ro_tick | input | 1 | Ring-oscillator clock edge tick |
| sub_tick | input | 1 | Subsystem clock edge tick |
| cpu_ce | output | 1 | CPU clock enable pulse, one per divided period |
| osc_stop | output | 1 | High-speed oscillator stop control |
| fb_off | output | 1 | Subsystem feedback resistor disable |
| sub_active | output | 1 | CPU currently runs from the subsystem clock |
| cfg_err | output | 1 | Sticky flag for a rejected write |

## Verification
A write is visible to a read issued on the next cycle, and the read data arrives one cycle after the read strobe. `cfg_err` rises one cycle after a rejected write. `cpu_ce` arrives one cycle after the source tick that closes a period. `sub_active` changes at that same edge. `osc_stop` and `fb_off` lag the stored bits and the active source by one more cycle. The bench steps a behavioural model at each rising edge, using the same input values the design sees. It compares every output on the following falling edge, so each result is checked in the exact cycle it is due and never one cycle early or late.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_RING = 2'd1,
    SRC_SUB  = 2'd2
  } clk_src_e;

  // Bit positions inside the control byte
  localparam int BIT_STOP  = 7;
  localparam int BIT_FBOFF = 6;
  localparam int BIT_STAT  = 5;
  localparam int BIT_SUB   = 4;
  localparam int BIT_RSVD  = 3;

  // Decide whether a written byte is an allowed combination
  function automatic logic cfg_legal(input logic [7:0] d,
                                     input logic       ring_mode,
                                     input int         xtal_max,
                                     input int         ring_max);
    int code;
    code = int'(d[2:0]);
    if (d[BIT_RSVD])     return 1'b0;
    if (d[BIT_SUB])      return (code == 0);
    if (ring_mode)       return (code <= ring_max);
    return (code <= xtal_max);
  endfunction

endpackage

// File: rtl/clkctl_cfg_reg.sv
module clkctl_cfg_reg
  import cpu_clk_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'hFFFB,
  parameter int          XTAL_MAX = 4,
  parameter int          RING_MAX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              main_mode,
  input  logic              sub_live,
  output logic [7:0]        cfg_o,
  output logic [7:0]        rdata_o,
  output logic              err_o
);

  // Bits that are never stored: the live status and the reserved bit
  localparam logic [7:0] STORE_MASK = ~((8'd1 << BIT_STAT) | (8'd1 << BIT_RSVD));

  logic [7:0] cfg_q;
  logic [7:0] rd_q;
  logic       err_q;
  logic       hit;
  logic       ok;
  logic [7:0] rd_view;

  assign hit = (bus_addr == REG_ADDR[ADDR_W-1:0]);
  assign ok  = cfg_legal(bus_wdata, main_mode, XTAL_MAX, RING_MAX);

  always_comb begin
    rd_view           = cfg_q;
    rd_view[BIT_STAT] = sub_live;
    rd_view[BIT_RSVD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= 8'h00;
      err_q <= 1'b0;
      rd_q  <= 8'h00;
    end else begin
      if (bus_wr && hit) begin
        if (ok) cfg_q <= bus_wdata & STORE_MASK;
        else    err_q <= 1'b1;
      end
      rd_q <= (bus_rd && hit) ? rd_view : 8'h00;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = rd_q;
  assign err_o   = err_q;

  // R7: the error flag never clears outside reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(err_q) |-> err_q);

  // R3: the unstored bits stay clear in the stored byte
  a_r3_unstored_clear: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[BIT_RSVD] == 1'b0) && (cfg_q[BIT_STAT] == 1'b0));

  // R7: a rejected write leaves the stored byte untouched
  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && !ok) |=> $stable(cfg_q));

  // R2: a write to another address leaves the stored byte untouched
  a_r2_miss_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> $stable(cfg_q));

endmodule

// File: rtl/clkctl_src_sel.sv
module clkctl_src_sel
  import cpu_clk_pkg::*;
#(
  parameter int XTAL_MAX = 4,
  parameter int RING_MAX = 1,
  parameter int SUB_LOG  = 1,
  parameter int LOG_W    = 3
) (
  input  logic [7:0]       cfg,
  input  logic             main_mode,
  input  clk_src_e         act_src,
  input  logic             hs_tick,
  input  logic             ro_tick,
  input  logic             sub_tick,
  output clk_src_e         nxt_src,
  output logic [LOG_W-1:0] nxt_log,
  output logic             act_tick
);

  logic [2:0] code;
  assign code = cfg[2:0];

  // Source and ratio that the next period would use
  always_comb begin
    if (cfg[BIT_SUB]) begin
      nxt_src = SRC_SUB;
      nxt_log = LOG_W'(SUB_LOG);
    end else if (main_mode) begin
      nxt_src = SRC_RING;
      nxt_log = (int'(code) > RING_MAX) ? LOG_W'(RING_MAX) : LOG_W'(code);
    end else begin
      nxt_src = SRC_XTAL;
      nxt_log = (int'(code) > XTAL_MAX) ? LOG_W'(XTAL_MAX) : LOG_W'(code);
    end
  end

  // Tick of the source that currently drives the counter
  always_comb begin
    unique case (act_src)
      SRC_RING: act_tick = ro_tick;
      SRC_SUB:  act_tick = sub_tick;
      default:  act_tick = hs_tick;
    endcase
  end

endmodule

// File: rtl/clkctl_prescale.sv
module clkctl_prescale
  import cpu_clk_pkg::*;
#(
  parameter int LOG_MAX  = 4,
  parameter int RING_MAX = 1,
  parameter int SUB_LOG  = 1,
  parameter int LOG_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  clk_src_e         nxt_src,
  input  logic [LOG_W-1:0] nxt_log,
  output logic             ce_o,
  output clk_src_e         act_src_o,
  output logic [LOG_W-1:0] act_log_o
);

  localparam int CNT_W = (LOG_MAX < 1) ? 1 : LOG_MAX;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             ce_q;
  clk_src_e         src_q;
  logic [LOG_W-1:0] log_q;
  logic             wrap;

  assign lim  = ~({CNT_W{1'b1}} << log_q);
  assign wrap = tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ce_q  <= 1'b0;
      src_q <= SRC_XTAL;
      log_q <= '0;
    end else begin
      ce_q <= wrap;
      if (wrap) begin
        cnt   <= '0;
        src_q <= nxt_src;
        log_q <= nxt_log;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ce_o      = ce_q;
  assign act_src_o = src_q;
  assign act_log_o = log_q;

  // R4: every enable pulse follows a tick of the active source
  a_r4_ce_after_tick: assert property (@(posedge clk) disable iff (rst)
    ce_q |-> $past(tick));

  // R4: the period counter stays inside the current period
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);

  // R8: the active source and ratio move only with an enable pulse
  a_r8_switch_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (!$stable(src_q) || !$stable(log_q)) |-> ce_q);

  // R5: the ring path never runs a ratio beyond its limit
  a_r5_ring_ratio: assert property (@(posedge clk) disable iff (rst)
    (src_q == SRC_RING) |-> (int'(log_q) <= RING_MAX));

  // R6: the subsystem path always runs its fixed ratio
  a_r6_sub_ratio: assert property (@(posedge clk) disable iff (rst)
    (src_q == SRC_SUB) |-> (int'(log_q) == SUB_LOG));

endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
  import cpu_clk_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'hFFFB,
  parameter int          XTAL_MAX = 4,
  parameter int          RING_MAX = 1,
  parameter int          SUB_LOG  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              main_mode,
  input  logic              hs_tick,
  input  logic              ro_tick,
  input  logic              sub_tick,
  output logic              cpu_ce,
  output logic              osc_stop,
  output logic              fb_off,
  output logic              sub_active,
  output logic              cfg_err
);

  localparam int LOG_MAX = (XTAL_MAX > SUB_LOG) ? XTAL_MAX : SUB_LOG;
  localparam int LOG_W   = $clog2(LOG_MAX + 1);

  logic [7:0]       cfg;
  clk_src_e         act_src;
  clk_src_e         nxt_src;
  logic [LOG_W-1:0] nxt_log;
  logic [LOG_W-1:0] act_log;
  logic             act_tick;
  logic             on_sub;
  logic             stop_q;
  logic             fb_q;

  assign on_sub = (act_src == SRC_SUB);

  clkctl_cfg_reg #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
    .XTAL_MAX(XTAL_MAX), .RING_MAX(RING_MAX)
  ) u_reg (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .main_mode(main_mode), .sub_live(on_sub),
    .cfg_o(cfg), .rdata_o(bus_rdata), .err_o(cfg_err)
  );

  clkctl_src_sel #(
    .XTAL_MAX(XTAL_MAX), .RING_MAX(RING_MAX),
    .SUB_LOG(SUB_LOG), .LOG_W(LOG_W)
  ) u_sel (
    .cfg(cfg), .main_mode(main_mode), .act_src(act_src),
    .hs_tick(hs_tick), .ro_tick(ro_tick), .sub_tick(sub_tick),
    .nxt_src(nxt_src), .nxt_log(nxt_log), .act_tick(act_tick)
  );

  clkctl_prescale #(
    .LOG_MAX(LOG_MAX), .RING_MAX(RING_MAX),
    .SUB_LOG(SUB_LOG), .LOG_W(LOG_W)
  ) u_div (
    .clk(clk), .rst(rst), .tick(act_tick),
    .nxt_src(nxt_src), .nxt_log(nxt_log),
    .ce_o(cpu_ce), .act_src_o(act_src), .act_log_o(act_log)
  );

  // Registered oscillator controls
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      stop_q <= cfg[BIT_STOP] && on_sub;
      fb_q   <= cfg[BIT_FBOFF];
    end
  end

  assign osc_stop   = stop_q;
  assign fb_off     = fb_q;
  assign sub_active = on_sub;

  // R9: the stop control is only ever raised after a cycle on the subsystem clock
  a_r9_stop_needs_sub: assert property (@(posedge clk) disable iff (rst)
    osc_stop |-> $past(sub_active));

  // R11: a change of the status flag coincides with a period boundary
  a_r11_status_on_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(sub_active) |-> cpu_ce);

  // R6: the subsystem path is never active with a ratio other than its fixed one
  a_r6_sub_fixed: assert property (@(posedge clk) disable iff (rst)
    sub_active |-> (int'(act_log) == SUB_LOG));

endmodule

// File: tb/tb_cpu_clk_ctrl.sv
module tb_cpu_clk_ctrl;

  localparam logic [15:0] RADDR = 16'hFFFB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        main_mode = 1'b0;
  logic        hs_tick = 1'b0;
  logic        ro_tick = 1'b0;
  logic        sub_tick = 1'b0;
  logic        cpu_ce, osc_stop, fb_off, sub_active, cfg_err;

  int    tests = 0;
  int    fails = 0;
  bit    started = 0;
  bit    done = 0;
  string phase = "R1 reset state";
  int    hs_pct = 10;
  int    ro_pct = 6;
  int    sub_pct = 3;

  // Reference model state
  logic [7:0] m_cfg = 8'h00;
  bit         m_err = 0;
  int         m_src = 0;
  int         m_lg = 0;
  int         m_cnt = 0;
  bit         e_ce = 0, e_osc = 0, e_fb = 0;
  logic [7:0] e_rd = 8'h00;

  cpu_clk_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_mode(main_mode),
    .hs_tick(hs_tick), .ro_tick(ro_tick), .sub_tick(sub_tick),
    .cpu_ce(cpu_ce), .osc_stop(osc_stop), .fb_off(fb_off),
    .sub_active(sub_active), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  function automatic bit ok_write(input logic [7:0] d, input logic mode);
    if (d[3]) return 0;
    if (d[4]) return d[2:0] == 3'd0;
    if (mode) return d[2:0] <= 3'd1;
    return d[2:0] <= 3'd4;
  endfunction

  // Model steps on each rising edge using the values the design samples
  always @(posedge clk) begin
    bit         tk;
    logic [7:0] old_cfg;
    int         old_src;
    started = 1;
    if (rst) begin
      m_cfg = 8'h00; m_err = 0; m_src = 0; m_lg = 0; m_cnt = 0;
      e_ce = 0; e_osc = 0; e_fb = 0; e_rd = 8'h00;
    end else begin
      old_cfg = m_cfg;
      old_src = m_src;
      e_rd = 8'h00;
      if (bus_rd && bus_addr == RADDR) begin
        e_rd = old_cfg & 8'hD7;
        e_rd[5] = (old_src == 2);
      end
      e_osc = old_cfg[7] && (old_src == 2);
      e_fb  = old_cfg[6];
      tk = (m_src == 0) ? hs_tick : (m_src == 1) ? ro_tick : sub_tick;
      e_ce = 0;
      if (tk) begin
        if (m_cnt == (1 << m_lg) - 1) begin
          m_cnt = 0;
          e_ce = 1;
          if (old_cfg[4]) begin m_src = 2; m_lg = 1; end
          else if (main_mode) begin m_src = 1; m_lg = (old_cfg[2:0] == 0) ? 0 : 1; end
          else begin m_src = 0; m_lg = int'(old_cfg[2:0]); end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      if (bus_wr && bus_addr == RADDR) begin
        if (ok_write(bus_wdata, main_mode)) m_cfg = bus_wdata & 8'hD7;
        else m_err = 1;
      end
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  // Compare every output away from the rising edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("cpu_ce", {7'd0, cpu_ce}, {7'd0, e_ce});
      chk("sub_active", {7'd0, sub_active}, {7'd0, (m_src == 2)});
      chk("osc_stop", {7'd0, osc_stop}, {7'd0, e_osc});
      chk("fb_off", {7'd0, fb_off}, {7'd0, e_fb});
      chk("cfg_err", {7'd0, cfg_err}, {7'd0, m_err});
      chk("bus_rdata", bus_rdata, e_rd);
    end
  end

  // Source tick generator
  always @(negedge clk) begin
    hs_tick  <= ($urandom_range(0, 9) < hs_pct);
    ro_tick  <= ($urandom_range(0, 9) < ro_pct);
    sub_tick <= ($urandom_range(0, 9) < sub_pct);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    phase = "R1 reset state";
    idle(2);
    rd(RADDR);
    idle(10);

    phase = "R4 crystal divide";
    for (int c = 0; c <= 4; c++) begin
      wr(RADDR, 8'(c));
      rd(RADDR);
      idle(90);
    end
    hs_pct = 10;
    wr(RADDR, 8'h02);
    idle(40);

    phase = "R8 boundary switch";
    wr(RADDR, 8'h04);
    idle(40);
    wr(RADDR, 8'h00);
    idle(30);
    wr(RADDR, 8'h03);
    idle(3);
    wr(RADDR, 8'h01);
    idle(30);

    phase = "R2 address decode";
    wr(16'hFFFA, 8'h03);
    rd(16'hFFFA);
    rd(RADDR);
    wr(16'h7FFB, 8'h10);
    rd(RADDR);
    idle(10);

    phase = "R7 rejected write";
    hs_pct = 7;
    wr(RADDR, 8'h08);
    rd(RADDR);
    wr(RADDR, 8'h05);
    wr(RADDR, 8'h07);
    rd(RADDR);
    idle(20);

    phase = "R5 ring path";
    main_mode = 1'b1;
    wr(RADDR, 8'h00);
    idle(40);
    wr(RADDR, 8'h01);
    rd(RADDR);
    idle(60);
    wr(RADDR, 8'h02);
    wr(RADDR, 8'h04);
    rd(RADDR);
    idle(40);

    phase = "R10 ring clamp";
    main_mode = 1'b0;
    wr(RADDR, 8'h03);
    idle(60);
    main_mode = 1'b1;
    idle(80);
    main_mode = 1'b0;
    idle(60);

    phase = "R6 R11 R3 subsystem path";
    wr(RADDR, 8'h10);
    idle(40);
    rd(RADDR);
    wr(RADDR, 8'h11);
    wr(RADDR, 8'h3C);
    rd(RADDR);
    idle(40);

    phase = "R9 oscillator controls";
    wr(RADDR, 8'hD0);
    idle(30);
    rd(RADDR);
    wr(RADDR, 8'hF1);
    idle(30);
    wr(RADDR, 8'h80);
    idle(60);
    rd(RADDR);
    wr(RADDR, 8'h40);
    idle(30);

    phase = "R1 reset again";
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(2);
    rd(RADDR);
    idle(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule